// File: doc/BRIEF.md
# Mailbox receive FIFO

This block is the receive side of an inter-processor mailbox. Remote producers hand it entries through a valid/ready push port. Each entry is a 3-bit channel number plus a 64-bit message, and the entries are kept in a circular buffer. Software sees the oldest entry through three read-only registers: channel, low word and high word. Writing the pop register then retires that entry.

Occupancy is not given as a count. Software reads a status word holding the raw write and read positions and a full flag. Equal positions mean full when the flag is set and empty when it is clear. A sticky pending bit records that the buffer held data. It drives an interrupt line through a 5-bit mask register, and bit 0 of that register gates it. Software can empty the buffer with a single register write. A depth register reports the capacity minus one.

The register interface is a 6-bit byte address with a write strobe and a combinational read path. The offsets are: 0x00 channel, 0x04 low word, 0x08 high word, 0x0C pop, 0x10 buffer reset, 0x14 status, 0x18 pending, 0x1C mask, 0x24 depth. Unmapped offsets read as zero.

Top module: `mbox_rx_fifo`

## Requirements
- R1: After reset the status word at 0x14 reads 0, pending at 0x18 reads 0, the mask at 0x1C reads 0x1F, irq is low and push_ready is high.
- R2: The register at 0x24 reads DEPTH-1, which is 7 by default.
- R3: The status word holds the read position in bits 31:24, the write position in bits 23:16 and the full flag in bit 0; the other bits are 0. Each position advances by one per push or pop and wraps from DEPTH-1 to 0.
- R4: The oldest entry is shown at 0x00 (channel in bits 2:0), 0x04 (message bits 31:0) and 0x08 (message bits 63:32). Entries leave in the order they were pushed.
- R5: A write to 0x0C with bit 0 set pops one entry. A write to 0x0C with bit 0 clear has no effect.
- R6: A pop write while the buffer is empty changes neither position nor the full flag.
- R7: After DEPTH pushes with no pop, the full flag is 1 and push_ready is 0. A push offered while full leaves the status word and the oldest entry unchanged.
- R8: Pending (0x18 bit 0) becomes 1 one cycle after the buffer turns non-empty. It stays 1 after the buffer drains. Writing 1 to bit 0 of 0x18 clears it; if entries remain, it becomes 1 again on the following cycle.
- R9: The mask register is 5 bits wide (bits 31:5 read 0). irq is high exactly when pending is 1 and mask bit 0 is 0.
- R10: Writing 0 to 0x10 sets both positions to 0 and clears the full flag and pending. A non-zero write to 0x10 has no effect.
- R11: A push and a pop in the same cycle advance both positions and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Producer offers an entry |
| push_ready | output | 1 | Entry accepted this cycle when valid |
| push_chan | input | 3 | Channel number of the offered entry |
| push_msg | input | 64 | Message of the offered entry |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Unmasked pending interrupt |

## Verification
A wrong pointer or full flag is visible at once in the status word at the next read. A wrong head pointer shows up when the entry registers return a message out of order. A stale pending bit shows up on irq one cycle late or one cycle too long. This matters most around a clear while entries remain, so that case is checked on both the cycle of the clear and the cycle after it. Wraparound and the refused push when full are checked across a full fill and drain that starts from a non-zero position.

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo #(
  parameter int DEPTH  = 8,
  parameter int CH_W   = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [CH_W-1:0]   push_chan,
  input  logic [DATA_W-1:0] push_msg,
  input  logic              reg_we,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = CH_W + DATA_W;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  localparam logic [5:0] A_CHAN = 6'h00, A_LO = 6'h04, A_HI = 6'h08, A_POP = 6'h0C,
                         A_RST = 6'h10, A_STS = 6'h14, A_PEND = 6'h18, A_MASK = 6'h1C,
                         A_DEPTH = 6'h24;

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_pos, rd_pos;
  logic          full, pending;
  logic [4:0]    mask;

  wire empty    = (wr_pos == rd_pos) && !full;
  wire buf_rst  = reg_we && reg_addr == A_RST && reg_wdata == 32'd0;
  wire pop_req  = reg_we && reg_addr == A_POP && reg_wdata[0];
  wire pend_clr = reg_we && reg_addr == A_PEND && reg_wdata[0];
  assign push_ready = !full && !buf_rst;
  wire push_acc = push_valid && push_ready;
  wire pop_acc  = pop_req && !empty && !buf_rst;

  wire [PW-1:0] wr_nxt = (wr_pos == LAST) ? '0 : wr_pos + 1'b1;
  wire [PW-1:0] rd_nxt = (rd_pos == LAST) ? '0 : rd_pos + 1'b1;

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_pos] <= {push_chan, push_msg};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pos  <= '0;
      rd_pos  <= '0;
      full    <= 1'b0;
      pending <= 1'b0;
      mask    <= 5'h1F;
    end else begin
      if (reg_we && reg_addr == A_MASK) mask <= reg_wdata[4:0];
      if (buf_rst) begin
        wr_pos  <= '0;
        rd_pos  <= '0;
        full    <= 1'b0;
        pending <= 1'b0;
      end else begin
        if (push_acc) wr_pos <= wr_nxt;
        if (pop_acc)  rd_pos <= rd_nxt;
        if (push_acc && !pop_acc)      full <= (wr_nxt == rd_pos);
        else if (pop_acc && !push_acc) full <= 1'b0;
        pending <= pend_clr ? 1'b0 : (pending || !empty);
      end
    end
  end

  assign irq = pending && !mask[0];

  wire [EW-1:0] head = mem[rd_pos];

  always_comb begin
    unique case (reg_addr)
      A_CHAN:  reg_rdata = 32'(head[EW-1 -: CH_W]);
      A_LO:    reg_rdata = head[31:0];
      A_HI:    reg_rdata = head[63:32];
      A_STS:   reg_rdata = {8'(rd_pos), 8'(wr_pos), 15'd0, full};
      A_PEND:  reg_rdata = {31'd0, pending};
      A_MASK:  reg_rdata = {27'd0, mask};
      A_DEPTH: reg_rdata = 32'(DEPTH - 1);
      default: reg_rdata = 32'd0;
    endcase
  end

  assert_full_refuses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push_ready);
  assert_full_pos_equal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> wr_pos == rd_pos);
  assert_empty_pop_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_valid && !buf_rst) |=> $stable(rd_pos) && $stable(wr_pos) && !full);
  assert_pending_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pend_clr && !buf_rst) |=> pending);
  assert_buf_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rst |=> (wr_pos == '0) && (rd_pos == '0) && !full && !pending);
  assert_simul_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_acc) |=> $stable(full));
endmodule

// File: tb/tb_mbox_rx_fifo.sv
module tb_mbox_rx_fifo;
  logic clk = 0, rst_n = 0;
  logic push_valid = 0, push_ready;
  logic [2:0] push_chan = 0;
  logic [63:0] push_msg = 0;
  logic reg_we = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq;
  int checks = 0, failures = 0;
  logic [66:0] q[$];
  logic [31:0] v;

  always #2 clk = ~clk;

  mbox_rx_fifo dut (.clk, .rst_n, .push_valid, .push_ready, .push_chan, .push_msg,
                    .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic push(logic [2:0] c, logic [63:0] m);
    @(negedge clk); push_valid = 1; push_chan = c; push_msg = m;
    if (push_ready) q.push_back({c, m});
    @(negedge clk); push_valid = 0;
  endtask

  task automatic check_head(string req);
    logic [66:0] e = q[0];
    rd(6'h00, v); chk(req, v, 32'(e[66:64]));
    rd(6'h04, v); chk(req, v, e[31:0]);
    rd(6'h08, v); chk(req, v, e[63:32]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rd(6'h14, v); chk("R1 status", v, 0);
    rd(6'h18, v); chk("R1 pending", v, 0);
    rd(6'h1C, v); chk("R1 mask", v, 32'h1F);
    chk("R1 irq", irq, 0);
    chk("R1 ready", push_ready, 1);
    rd(6'h24, v); chk("R2 depth", v, 7);
  endtask

  task automatic t_single;
    push(3'd5, 64'hA5A5_0001_DEAD_BEEF);
    rd(6'h14, v); chk("R3 status after push", v, 32'h0001_0000);
    check_head("R4 head single");
    @(negedge clk);
    rd(6'h18, v); chk("R8 pending set", v, 1);
    chk("R9 irq masked", irq, 0);
    wr(6'h1C, 32'hFFFF_FFE0);
    rd(6'h1C, v); chk("R9 mask width", v, 0);
    chk("R9 irq unmasked", irq, 1);
    wr(6'h0C, 32'h2);
    rd(6'h14, v); chk("R5 pop bit0 clear", v, 32'h0001_0000);
    wr(6'h0C, 32'h1); void'(q.pop_front());
    rd(6'h14, v); chk("R5 pop", v, 32'h0101_0000);
    @(negedge clk);
    rd(6'h18, v); chk("R8 sticky after drain", v, 1);
    wr(6'h18, 32'h1);
    @(negedge clk);
    rd(6'h18, v); chk("R8 clear empty", v, 0);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_empty_pop;
    wr(6'h0C, 32'h1);
    rd(6'h14, v); chk("R6 empty pop", v, 32'h0101_0000);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 8; i++) push(3'(i), {32'(i) ^ 32'hC0DE_0000, 32'h1000_0000 + 32'(i)});
    rd(6'h14, v); chk("R7 full status", v, 32'h0101_0001);
    chk("R7 ready low", push_ready, 0);
    push(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(6'h14, v); chk("R7 refused push status", v, 32'h0101_0001);
    check_head("R7 head kept");
    for (int i = 0; i < 3; i++) begin
      check_head("R4 order");
      wr(6'h0C, 32'h1); void'(q.pop_front());
    end
    rd(6'h14, v); chk("R3 partial", v, 32'h0401_0000);
    for (int i = 0; i < 5; i++) begin
      check_head("R4 order wrap");
      wr(6'h0C, 32'h1); void'(q.pop_front());
    end
    rd(6'h14, v); chk("R3 wrapped empty", v, 32'h0101_0000);
  endtask

  task automatic t_reassert;
    push(3'd1, 64'h1111_2222_3333_4444);
    push(3'd2, 64'h5555_6666_7777_8888);
    @(negedge clk);
    @(negedge clk); reg_we = 1; reg_addr = 6'h18; reg_wdata = 1;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
    rd(6'h18, v); chk("R8 cleared", v, 0);
    @(negedge clk);
    rd(6'h18, v); chk("R8 reasserts", v, 1);
  endtask

  task automatic t_simul;
    @(negedge clk);
    push_valid = 1; push_chan = 3'd3; push_msg = 64'h9999_AAAA_BBBB_CCCC;
    reg_we = 1; reg_addr = 6'h0C; reg_wdata = 1;
    q.push_back({3'd3, 64'h9999_AAAA_BBBB_CCCC});
    @(negedge clk); push_valid = 0; reg_we = 0; reg_wdata = 0;
    void'(q.pop_front());
    rd(6'h14, v); chk("R11 simul status", v, 32'h0204_0000);
    check_head("R11 head");
  endtask

  task automatic t_buf_reset;
    wr(6'h10, 32'h5);
    rd(6'h14, v); chk("R10 nonzero ignored", v, 32'h0204_0000);
    wr(6'h10, 32'h0);
    rd(6'h14, v); chk("R10 status", v, 0);
    rd(6'h18, v); chk("R10 pending", v, 0);
    chk("R10 irq", irq, 0);
  endtask

  initial begin
    #10 rst_n = 1;
    t_reset;
    t_single;
    t_empty_pop;
    t_fill;
    t_reassert;
    t_simul;
    t_buf_reset;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule